// File: doc/BRIEF.md
# Sleep-Mode Power Sequencer

This block steps a system into and out of its sleep states by driving rail-request, clock-request and DRAM self-refresh lines toward an external power management chip. A static configuration input picks one of three suspend depths. A deep suspend removes both the CPU and core supplies and parks DRAM in self-refresh. A medium suspend removes only the CPU supply and keeps self-refresh. A light suspend removes only the CPU supply and leaves DRAM running. Each rail has its own programmed power-off delay, applied on the way down, and its own power-good delay, applied on the way up. The core power-good delay is split into an oscillator-settle part followed by a supply-settle part.

All delays are counted on a single-cycle enable pulse derived from a 32.768 kHz reference, sampled in the fast system clock domain. The core request and system clock request pins each have a selectable polarity. An option merges the CPU and core requests onto the core request pin. Another option makes wake wait for a power-good input from the external regulator. The interrupt line from the power management chip is forwarded, optionally inverted, through one register stage. No other processing is applied to it.

Top module: `sleep_pwr_seq`

## Requirements
- R1: With `cfg_depth`=0, once asleep the CPU request is low, the logical core request and logical clock request are both off, and `dram_sr_req` is high.
- R2: With `cfg_depth`=1, once asleep the CPU request is low, the logical core and clock requests stay on, and `dram_sr_req` is high.
- R3: With `cfg_depth`=2 (and also with the value 3), once asleep the CPU request is low, the core and clock requests stay on, and `dram_sr_req` stays low.
- R4: A `sleep_req` sampled high while running drops `cpu_pwr_req` and `cpu_run` at the next clock edge. The CPU power-off wait then ends on the (N+1)-th tick for a programmed value N, so a value of 0 ends on the next tick. In deep mode the core power-off wait follows in the same way.
- R5: On wake in deep mode, the core and clock requests return first. The oscillator wait (N+1 ticks) and then the supply wait (M+1 ticks) run before `cpu_pwr_req` rises. In every mode, the CPU power-good wait (K+1 ticks) runs before `cpu_run` rises. Self-refresh is held until the CPU request rises.
- R6: The pin `core_pwr_req_o` equals the logical core request when `cfg_core_hi`=1, and its inverse when 0. The pin `sys_clk_req_o` follows the same rule with `cfg_clk_hi` and the logical clock request.
- R7: With `cfg_combined`=1, the logical request shown on `core_pwr_req_o` is the AND of the CPU request and the core request.
- R8: With `cfg_pgood_en`=1, after the CPU power-good wait `cpu_run` stays low until `cpu_pgood` is sampled high. It then rises at the next edge.
- R9: `irq_out` equals `pmu_irq ^ cfg_irq_inv` as sampled at the previous clock edge.
- R10: A `wake_req` during the entry sequence is held and serviced once sleep is reached, without aborting entry. A `sleep_req` outside the running state is ignored. A `wake_req` while running, or during the wake sequence, is ignored.
- R11: After reset the block is running: `cpu_pwr_req`=1, `cpu_run`=1, `dram_sr_req`=0, and the core and clock requests are on (pins at their active level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable pulse at the 32.768 kHz rate |
| cfg_depth | input | 2 | Suspend depth: 0 deep, 1 medium, 2 or 3 light |
| cfg_cpu_off_dly | input | DLY_W | CPU power-off wait, in ticks |
| cfg_cpu_good_dly | input | DLY_W | CPU power-good wait, in ticks |
| cfg_core_off_dly | input | DLY_W | Core power-off wait, in ticks |
| cfg_osc_dly | input | DLY_W | Core oscillator-settle wait, in ticks |
| cfg_core_good_dly | input | DLY_W | Core supply-settle wait, in ticks |
| cfg_core_hi | input | 1 | Core request pin active level is high |
| cfg_clk_hi | input | 1 | Clock request pin active level is high |
| cfg_combined | input | 1 | Merge CPU and core requests on the core pin |
| cfg_pgood_en | input | 1 | Wait for `cpu_pgood` on wake |
| cfg_irq_inv | input | 1 | Invert the forwarded interrupt |
| sleep_req | input | 1 | Sleep command, sampled every clock |
| wake_req | input | 1 | Wake event, sampled every clock |
| cpu_pgood | input | 1 | CPU power-good from the regulator |
| pmu_irq | input | 1 | Interrupt from the power management chip |
| cpu_pwr_req | output | 1 | CPU rail request, high means on |
| core_pwr_req_o | output | 1 | Core rail request pin, polarity per `cfg_core_hi` |
| sys_clk_req_o | output | 1 | System clock request pin, polarity per `cfg_clk_hi` |
| dram_sr_req | output | 1 | DRAM self-refresh request |
| cpu_run | output | 1 | CPU released and running |
| irq_out | output | 1 | Forwarded interrupt |

## Verification
Every output is decoded from the sequencer state and registered. A wrong state or a wrong depth latch therefore appears on the request pins at the very edge where the state is entered. A delay counter that is off by one shifts a request edge by a whole tick period, which is several system clocks. The cycle-by-cycle model makes such a shift visible at the first mismatched edge. A lost or spurious wake latch shows as a sleep state that never ends, or one that ends with no wake event. This is caught within one tick period of the point where the model and the design part.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_CPU_DN    = 3'd1,
    ST_CORE_DN   = 3'd2,
    ST_SLEEP     = 3'd3,
    ST_CORE_OSC  = 3'd4,
    ST_CORE_GOOD = 3'd5,
    ST_CPU_UP    = 3'd6,
    ST_PG_WAIT   = 3'd7
  } seq_state_e;

  localparam logic [1:0] DEPTH_DEEP  = 2'd0;
  localparam logic [1:0] DEPTH_MID   = 2'd1;
  localparam logic [1:0] DEPTH_LIGHT = 2'd2;

  typedef struct packed {
    logic cpu_on;
    logic core_on;
    logic clk_on;
    logic self_ref;
    logic run;
  } rail_req_t;

  // Fold the unused depth code onto the light mode
  function automatic logic [1:0] norm_depth(input logic [1:0] d);
    return (d == 2'd3) ? DEPTH_LIGHT : d;
  endfunction

  // Logical requests for a given sequencer state and latched depth
  function automatic rail_req_t decode(input seq_state_e s, input logic [1:0] d);
    rail_req_t r;
    r = '{cpu_on: 1'b1, core_on: 1'b1, clk_on: 1'b1, self_ref: 1'b0, run: 1'b0};
    case (s)
      ST_RUN:       r.run = 1'b1;
      ST_CPU_DN:    r.cpu_on = 1'b0;
      ST_CORE_DN: begin
        r.cpu_on  = 1'b0;
        r.core_on = 1'b0;
        r.clk_on  = 1'b0;
      end
      ST_SLEEP: begin
        r.cpu_on   = 1'b0;
        r.core_on  = (d != DEPTH_DEEP);
        r.clk_on   = (d != DEPTH_DEEP);
        r.self_ref = (d != DEPTH_LIGHT);
      end
      ST_CORE_OSC, ST_CORE_GOOD: begin
        r.cpu_on   = 1'b0;
        r.self_ref = 1'b1;
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pseq_tick_timer.sv
module pseq_tick_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             expired
);

  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // A step ends on the first tick seen with the count already at zero
  assign expired = tick && (cnt_q == '0);

endmodule

// File: rtl/pseq_fsm.sv
module pseq_fsm
  import pseq_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_depth,
  input  logic [DLY_W-1:0] cfg_cpu_off_dly,
  input  logic [DLY_W-1:0] cfg_cpu_good_dly,
  input  logic [DLY_W-1:0] cfg_core_off_dly,
  input  logic [DLY_W-1:0] cfg_osc_dly,
  input  logic [DLY_W-1:0] cfg_core_good_dly,
  input  logic             cfg_pgood_en,
  input  logic             sleep_req,
  input  logic             wake_req,
  input  logic             cpu_pgood,
  input  logic             expired,
  output logic             load,
  output logic [DLY_W-1:0] load_val,
  output seq_state_e       state_d,
  output logic [1:0]       depth_d
);

  seq_state_e state_q;
  logic [1:0] depth_q;
  logic       pend_q, pend_d;
  logic       in_entry;

  assign in_entry = (state_q == ST_CPU_DN) || (state_q == ST_CORE_DN) ||
                    (state_q == ST_SLEEP);

  always_comb begin
    state_d  = state_q;
    depth_d  = depth_q;
    load     = 1'b0;
    load_val = '0;
    case (state_q)
      ST_RUN: if (sleep_req) begin
        state_d  = ST_CPU_DN;
        depth_d  = norm_depth(cfg_depth);
        load     = 1'b1;
        load_val = cfg_cpu_off_dly;
      end
      ST_CPU_DN: if (expired) begin
        if (depth_q == DEPTH_DEEP) begin
          state_d  = ST_CORE_DN;
          load     = 1'b1;
          load_val = cfg_core_off_dly;
        end else begin
          state_d = ST_SLEEP;
        end
      end
      ST_CORE_DN: if (expired) state_d = ST_SLEEP;
      ST_SLEEP: if (wake_req || pend_q) begin
        load = 1'b1;
        if (depth_q == DEPTH_DEEP) begin
          state_d  = ST_CORE_OSC;
          load_val = cfg_osc_dly;
        end else begin
          state_d  = ST_CPU_UP;
          load_val = cfg_cpu_good_dly;
        end
      end
      ST_CORE_OSC: if (expired) begin
        state_d  = ST_CORE_GOOD;
        load     = 1'b1;
        load_val = cfg_core_good_dly;
      end
      ST_CORE_GOOD: if (expired) begin
        state_d  = ST_CPU_UP;
        load     = 1'b1;
        load_val = cfg_cpu_good_dly;
      end
      ST_CPU_UP: if (expired) state_d = cfg_pgood_en ? ST_PG_WAIT : ST_RUN;
      ST_PG_WAIT: if (cpu_pgood) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  // Wake latch: armed during entry and sleep, consumed when sleep is left
  always_comb begin
    pend_d = pend_q;
    if ((state_q == ST_SLEEP) && (state_d != ST_SLEEP)) begin
      pend_d = 1'b0;
    end else if (wake_req && in_entry) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      depth_q <= DEPTH_LIGHT;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      depth_q <= depth_d;
      pend_q  <= pend_d;
    end
  end

endmodule

// File: rtl/pseq_outmap.sv
module pseq_outmap
  import pseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_e state_d,
  input  logic [1:0] depth_d,
  input  logic       cfg_core_hi,
  input  logic       cfg_clk_hi,
  input  logic       cfg_combined,
  input  logic       cfg_irq_inv,
  input  logic       pmu_irq,
  output logic       cpu_pwr_req,
  output logic       core_pwr_req_o,
  output logic       sys_clk_req_o,
  output logic       dram_sr_req,
  output logic       cpu_run,
  output logic       irq_out,
  output logic       core_on_q
);

  rail_req_t nxt_req;
  logic      core_log;

  assign nxt_req  = rst ? decode(ST_RUN, DEPTH_LIGHT) : decode(state_d, depth_d);
  assign core_log = cfg_combined ? (nxt_req.cpu_on & nxt_req.core_on) : nxt_req.core_on;

  always_ff @(posedge clk) begin
    cpu_pwr_req    <= nxt_req.cpu_on;
    core_on_q      <= nxt_req.core_on;
    core_pwr_req_o <= cfg_core_hi ? core_log : ~core_log;
    sys_clk_req_o  <= cfg_clk_hi ? nxt_req.clk_on : ~nxt_req.clk_on;
    dram_sr_req    <= nxt_req.self_ref;
    cpu_run        <= nxt_req.run;
  end

  // Interrupt pass-through: one flop, no reset so it tracks from the first edge
  always_ff @(posedge clk) begin
    irq_out <= pmu_irq ^ cfg_irq_inv;
  end

endmodule

// File: rtl/sleep_pwr_seq.sv
module sleep_pwr_seq
  import pseq_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [1:0]       cfg_depth,
  input  logic [DLY_W-1:0] cfg_cpu_off_dly,
  input  logic [DLY_W-1:0] cfg_cpu_good_dly,
  input  logic [DLY_W-1:0] cfg_core_off_dly,
  input  logic [DLY_W-1:0] cfg_osc_dly,
  input  logic [DLY_W-1:0] cfg_core_good_dly,
  input  logic             cfg_core_hi,
  input  logic             cfg_clk_hi,
  input  logic             cfg_combined,
  input  logic             cfg_pgood_en,
  input  logic             cfg_irq_inv,
  input  logic             sleep_req,
  input  logic             wake_req,
  input  logic             cpu_pgood,
  input  logic             pmu_irq,
  output logic             cpu_pwr_req,
  output logic             core_pwr_req_o,
  output logic             sys_clk_req_o,
  output logic             dram_sr_req,
  output logic             cpu_run,
  output logic             irq_out
);

  logic             tmr_load;
  logic [DLY_W-1:0] tmr_val;
  logic             tmr_exp;
  seq_state_e       state_d;
  logic [1:0]       depth_d;
  logic             core_on_q;

  pseq_tick_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  pseq_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk               (clk),
    .rst               (rst),
    .cfg_depth         (cfg_depth),
    .cfg_cpu_off_dly   (cfg_cpu_off_dly),
    .cfg_cpu_good_dly  (cfg_cpu_good_dly),
    .cfg_core_off_dly  (cfg_core_off_dly),
    .cfg_osc_dly       (cfg_osc_dly),
    .cfg_core_good_dly (cfg_core_good_dly),
    .cfg_pgood_en      (cfg_pgood_en),
    .sleep_req         (sleep_req),
    .wake_req          (wake_req),
    .cpu_pgood         (cpu_pgood),
    .expired           (tmr_exp),
    .load              (tmr_load),
    .load_val          (tmr_val),
    .state_d           (state_d),
    .depth_d           (depth_d)
  );

  pseq_outmap u_out (
    .clk            (clk),
    .rst            (rst),
    .state_d        (state_d),
    .depth_d        (depth_d),
    .cfg_core_hi    (cfg_core_hi),
    .cfg_clk_hi     (cfg_clk_hi),
    .cfg_combined   (cfg_combined),
    .cfg_irq_inv    (cfg_irq_inv),
    .pmu_irq        (pmu_irq),
    .cpu_pwr_req    (cpu_pwr_req),
    .core_pwr_req_o (core_pwr_req_o),
    .sys_clk_req_o  (sys_clk_req_o),
    .dram_sr_req    (dram_sr_req),
    .cpu_run        (cpu_run),
    .irq_out        (irq_out),
    .core_on_q      (core_on_q)
  );

endmodule

// File: rtl/sleep_pwr_seq_chk.sv
module sleep_pwr_seq_chk (
  input logic clk,
  input logic rst,
  input logic cfg_combined,
  input logic cfg_core_hi,
  input logic cfg_pgood_en,
  input logic cfg_irq_inv,
  input logic cpu_pgood,
  input logic pmu_irq,
  input logic cpu_pwr_req,
  input logic core_pwr_req_o,
  input logic dram_sr_req,
  input logic cpu_run,
  input logic irq_out,
  input logic core_on
);

  // R4
  cpu_drop_from_run_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_pwr_req) |-> $past(cpu_run));

  // R5
  core_before_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_pwr_req) |-> core_on);

  // R5
  sr_excludes_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    dram_sr_req |-> !cpu_pwr_req);

  // R7
  combined_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_combined && !cpu_pwr_req) |-> (core_pwr_req_o == !cfg_core_hi));

  // R8
  pgood_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_pgood_en && $rose(cpu_run)) |-> $past(cpu_pgood));

  // R9
  irq_pass_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out == $past(pmu_irq ^ cfg_irq_inv));

endmodule

bind sleep_pwr_seq sleep_pwr_seq_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_combined   (cfg_combined),
  .cfg_core_hi    (cfg_core_hi),
  .cfg_pgood_en   (cfg_pgood_en),
  .cfg_irq_inv    (cfg_irq_inv),
  .cpu_pgood      (cpu_pgood),
  .pmu_irq        (pmu_irq),
  .cpu_pwr_req    (cpu_pwr_req),
  .core_pwr_req_o (core_pwr_req_o),
  .dram_sr_req    (dram_sr_req),
  .cpu_run        (cpu_run),
  .irq_out        (irq_out),
  .core_on        (core_on_q)
);

// File: tb/sim_sleep_pwr_seq.sv
`timescale 1ns/1ps
module sim_sleep_pwr_seq;

  localparam int DLY_W    = 16;
  localparam int TICK_DIV = 5;
  localparam int WDOG     = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [1:0] cfg_depth = 2'd0;
  logic [DLY_W-1:0] cpu_off = 16'd2, cpu_good = 16'd2, core_off = 16'd1;
  logic [DLY_W-1:0] osc = 16'd3, core_good = 16'd0;
  logic core_hi = 1'b1, clk_hi = 1'b1, combined = 1'b0, pg_en = 1'b0, irq_inv = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0, cpu_pgood = 1'b0, pmu_irq = 1'b0;
  logic cpu_pwr_req, core_pin, clk_pin, dram_sr, cpu_run, irq_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sleep_pwr_seq #(.DLY_W(DLY_W)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .cfg_depth(cfg_depth),
    .cfg_cpu_off_dly(cpu_off), .cfg_cpu_good_dly(cpu_good),
    .cfg_core_off_dly(core_off), .cfg_osc_dly(osc), .cfg_core_good_dly(core_good),
    .cfg_core_hi(core_hi), .cfg_clk_hi(clk_hi), .cfg_combined(combined),
    .cfg_pgood_en(pg_en), .cfg_irq_inv(irq_inv), .sleep_req(sleep_req),
    .wake_req(wake_req), .cpu_pgood(cpu_pgood), .pmu_irq(pmu_irq),
    .cpu_pwr_req(cpu_pwr_req), .core_pwr_req_o(core_pin), .sys_clk_req_o(clk_pin),
    .dram_sr_req(dram_sr), .cpu_run(cpu_run), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Tick pulse generator, driven just after the edge
  int tdiv = 0;
  always @(posedge clk) begin
    #1;
    tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
  end

  // Behavioural reference: phase 0 run, 1 cpu down, 2 core down, 3 asleep,
  // 4 osc settle, 5 supply settle, 6 cpu settle, 7 wait power-good
  int mph = 0, mcnt = 0, mdep = 2;
  bit mpend = 0;
  bit e_cpu, e_core, e_clk, e_sr, e_run, e_irq;
  bit model_ok = 0;

  always @(posedge clk) begin
    int nph;
    bit ex;
    bit lc, lcore, lclk;
    if (rst) begin
      mph = 0; mcnt = 0; mdep = 2; mpend = 0;
    end else begin
      nph = mph;
      ex = tick && (mcnt == 0);
      if (tick && mcnt > 0) mcnt = mcnt - 1;
      case (mph)
        0: if (sleep_req) begin nph = 1; mcnt = cpu_off; mdep = (cfg_depth == 3) ? 2 : cfg_depth; end
        1: if (ex) begin if (mdep == 0) begin nph = 2; mcnt = core_off; end else nph = 3; end
        2: if (ex) nph = 3;
        3: if (wake_req || mpend) begin
             if (mdep == 0) begin nph = 4; mcnt = osc; end
             else begin nph = 6; mcnt = cpu_good; end
           end
        4: if (ex) begin nph = 5; mcnt = core_good; end
        5: if (ex) begin nph = 6; mcnt = cpu_good; end
        6: if (ex) nph = pg_en ? 7 : 0;
        default: if (cpu_pgood) nph = 0;
      endcase
      if (mph == 3 && nph != 3) mpend = 0;
      else if (wake_req && mph >= 1 && mph <= 3) mpend = 1;
      mph = nph;
    end
    lc    = (mph == 0) || (mph >= 6);
    lcore = !(mph == 2 || (mph == 3 && mdep == 0));
    lclk  = lcore;
    e_cpu = lc;
    e_run = (mph == 0);
    e_sr  = (mph == 3 && mdep != 2) || mph == 4 || mph == 5;
    if (combined) lcore = lcore && lc;
    e_core = core_hi ? lcore : !lcore;
    e_clk  = clk_hi ? lclk : !lclk;
    e_irq  = pmu_irq ^ irq_inv;
    model_ok = 1;
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst && model_ok && !done) begin
      chk("R4 cpu request", int'(cpu_pwr_req), int'(e_cpu));
      chk("R6 core pin", int'(core_pin), int'(e_core));
      chk("R6 clock pin", int'(clk_pin), int'(e_clk));
      chk("R1 self-refresh", int'(dram_sr), int'(e_sr));
      chk("R5 cpu run", int'(cpu_run), int'(e_run));
      chk("R9 irq", int'(irq_out), int'(e_irq));
    end
    if (cyc == WDOG && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1; step(1); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_req = 1'b1; step(1); wake_req = 1'b0;
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    step(2);
    // R11 reset state
    chk("R11 cpu req", int'(cpu_pwr_req), 1);
    chk("R11 run", int'(cpu_run), 1);
    chk("R11 sr", int'(dram_sr), 0);
    chk("R11 core pin", int'(core_pin), 1);
    chk("R11 clk pin", int'(clk_pin), 1);

    // R1 deep suspend
    cfg_depth = 2'd0;
    pulse_sleep();
    chk("R4 cpu drops next edge", int'(cpu_pwr_req), 0);
    chk("R4 run drops next edge", int'(cpu_run), 0);
    step(60);
    chk("R1 cpu off", int'(cpu_pwr_req), 0);
    chk("R1 core off", int'(core_pin), 0);
    chk("R1 clk off", int'(clk_pin), 0);
    chk("R1 sr on", int'(dram_sr), 1);
    pulse_wake();
    step(2);
    chk("R5 core back first", int'(core_pin), 1);
    chk("R5 cpu still off", int'(cpu_pwr_req), 0);
    step(80);
    chk("R5 running again", int'(cpu_run), 1);

    // R2 medium suspend with low-active pins
    cfg_depth = 2'd1; core_hi = 1'b0; clk_hi = 1'b0;
    step(2);
    pulse_sleep();
    step(40);
    chk("R2 cpu off", int'(cpu_pwr_req), 0);
    chk("R2 core on (low active)", int'(core_pin), 0);
    chk("R6 clk on (low active)", int'(clk_pin), 0);
    chk("R2 sr on", int'(dram_sr), 1);
    pulse_wake();
    step(60);
    chk("R2 running", int'(cpu_run), 1);
    core_hi = 1'b1; clk_hi = 1'b1;

    // R3 light suspend with combined request; R10 sleep ignored while asleep
    cfg_depth = 2'd2; combined = 1'b1;
    step(2);
    pulse_sleep();
    step(40);
    chk("R3 sr off", int'(dram_sr), 0);
    chk("R7 combined core pin", int'(core_pin), 0);
    chk("R3 clk on", int'(clk_pin), 1);
    pulse_sleep();
    step(40);
    chk("R10 still asleep", int'(cpu_run), 0);
    pulse_wake();
    step(60);
    chk("R7 core pin back", int'(core_pin), 1);
    combined = 1'b0;

    // R3 code 3 behaves as light
    cfg_depth = 2'd3;
    step(2);
    pulse_sleep();
    step(40);
    chk("R3 code3 sr off", int'(dram_sr), 0);
    chk("R3 code3 core on", int'(core_pin), 1);
    pulse_wake();
    step(60);

    // R8 power-good gating
    pg_en = 1'b1; cpu_pgood = 1'b0; cfg_depth = 2'd1;
    step(2);
    pulse_sleep();
    step(40);
    pulse_wake();
    step(60);
    chk("R8 cpu req up", int'(cpu_pwr_req), 1);
    chk("R8 held for pgood", int'(cpu_run), 0);
    cpu_pgood = 1'b1;
    step(2);
    chk("R8 released", int'(cpu_run), 1);
    pg_en = 1'b0;

    // R10 wake during entry is held
    cpu_off = 16'd6;
    pulse_sleep();
    step(3);
    pulse_wake();
    step(2);
    chk("R10 entry not aborted", int'(cpu_pwr_req), 0);
    step(120);
    chk("R10 held wake serviced", int'(cpu_run), 1);
    pulse_wake();
    step(40);
    chk("R10 wake in run ignored", int'(cpu_run), 1);
    cpu_off = 16'd2;

    // R4 zero delays
    cpu_off = '0; cpu_good = '0; core_off = '0; osc = '0; core_good = '0;
    cfg_depth = 2'd0;
    pulse_sleep();
    chk("R4 zero-delay drop", int'(cpu_pwr_req), 0);
    step(30);
    chk("R4 zero-delay asleep", int'(dram_sr), 1);
    pulse_wake();
    step(40);
    chk("R4 zero-delay wake", int'(cpu_run), 1);

    // R9 interrupt forwarding
    pmu_irq = 1'b1; step(2);
    chk("R9 plain", int'(irq_out), 1);
    irq_inv = 1'b1; step(2);
    chk("R9 inverted", int'(irq_out), 0);
    pmu_irq = 1'b0; step(2);
    chk("R9 inverted low", int'(irq_out), 1);

    step(4);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule